// File: doc/BRIEF.md
# Multicycle Shared-Resource Processor Datapath

This block is the 32-bit datapath of a small multicycle processor with a load/store, three-operand instruction format. It holds the program counter, the instruction register, a memory data register, two operand registers, an ALU result register, a 32-entry register file and one ALU. A single memory port is used for instruction fetch and data access. The ALU is time-shared: it increments the PC, computes branch targets, computes load/store addresses and performs register-to-register operations in different cycles.

The block has no sequencing of its own. An external controller drives one set of select and enable inputs every cycle and reads back the opcode field, the function field and the ALU zero flag. Memory sits outside the block: it receives an address and write data and returns read data combinationally within the same cycle.

Instruction fields are fixed: opcode in bits 31..26, first source register (rs) in 25..21, second source or load destination (rt) in 20..16, R-type destination (rd) in 15..11, function in 5..0, 16-bit immediate in 15..0 and 26-bit jump index in 25..0.

Top module: `mcdp_top`

## Requirements
- R1: A synchronous active-high `rst` clears the PC to 0. When `addr_from_alu` is 0, `mem_addr` equals the PC.
- R2: When `addr_from_alu` is 1, `mem_addr` equals the ALU result register.
- R3: The instruction register loads `mem_rdata` only on an edge where `ir_load` is 1, and holds otherwise. `opcode` is IR bits 31..26 and `funct` is IR bits 5..0.
- R4: The memory data register, the ALU result register and the two operand registers load on every edge with no enable. The first operand register takes the register named by IR bits 25..21 and the second takes the register named by IR bits 20..16. `mem_wdata` is the second operand register.
- R5: ALU input A is the PC when `opa_from_reg` is 0 and the first operand register when it is 1. ALU input B is selected by `opb_sel`: 0 gives the second operand register, 1 gives the constant 4, 2 gives the sign-extended IR[15:0], and 3 gives the sign-extended IR[15:0] shifted left by 2.
- R6: `alu_op` selects the operation: 0 add, 1 subtract (A-B), 2 AND, 3 OR, 4 signed less-than (result 1 or 0), 5 XOR, 6 NOR, 7 unsigned less-than. `alu_zero` is 1 exactly when the current ALU result is 0.
- R7: The PC loads on an edge where `pc_wr` is 1, or where `pc_wr_cond` and `alu_zero` are both 1. Otherwise it holds.
- R8: The next PC is selected by `npc_sel`: 0 gives the live ALU result, 1 gives the ALU result register, 2 gives the jump target {PC[31:28], IR[25:0], 2'b00}, and 3 behaves as 0.
- R9: On an edge with `rf_we` 1, the register file writes the register named by IR[15:11] when `dst_from_rd` is 1, or by IR[20:16] otherwise. The write data is the memory data register when `wb_from_mdr` is 1, or the ALU result register otherwise.
- R10: Register 0 always reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by the ALU zero flag |
| addr_from_alu | input | 1 | Memory address from the ALU result register (1) or the PC (0) |
| ir_load | input | 1 | Instruction register load enable |
| opa_from_reg | input | 1 | ALU input A from the first operand register (1) or the PC (0) |
| opb_sel | input | 2 | ALU input B select |
| alu_op | input | 3 | ALU operation code |
| npc_sel | input | 2 | Next-PC source select |
| rf_we | input | 1 | Register file write enable |
| dst_from_rd | input | 1 | Destination register from the rd field (1) or the rt field (0) |
| wb_from_mdr | input | 1 | Write data from the memory data register (1) or the ALU result register (0) |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Address to the shared memory |
| mem_wdata | output | 32 | Store data (second operand register) |
| opcode | output | 6 | IR opcode field to the controller |
| funct | output | 6 | IR function field to the controller |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The hardest behaviour to reach from the ports is the conditional PC write. It depends on a branch target that was computed and parked in the ALU result register one cycle earlier, and on a zero flag produced by a subtraction of two register values in the current cycle. Both depend on register contents that only earlier loads can establish. The bench therefore acts as the controller. It first runs load sequences to place chosen values in the register file. It then runs branch sequences with equal and unequal operands, and checks the address of the following fetch against the PC it models itself. Stores then bring the register contents (register 0, R-type results, sign-extended offsets) out through the address and write-data ports.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_SLT  = 3'd4,
    ALU_XOR  = 3'd5,
    ALU_NOR  = 3'd6,
    ALU_SLTU = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG    = 2'd0,
    OPB_FOUR   = 2'd1,
    OPB_IMM    = 2'd2,
    OPB_IMM_X4 = 2'd3
  } opb_sel_e;

  typedef enum logic [1:0] {
    NPC_ALU  = 2'd0,
    NPC_HELD = 2'd1,
    NPC_JUMP = 2'd2,
    NPC_ALT  = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
      default:  y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  raddr_a,
  input  logic [RAW-1:0]  raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] cells [NREGS];
  logic [XLEN-1:0] a_q, b_q;
  logic            a_is_r0, b_is_r0;

  // Write port; the read registers double as the operand registers.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) cells[waddr] <= wdata;
    a_q     <= cells[raddr_a];
    b_q     <= cells[raddr_b];
    a_is_r0 <= (raddr_a == '0);
    b_is_r0 <= (raddr_b == '0);
  end

  assign rdata_a = a_is_r0 ? '0 : a_q;
  assign rdata_b = b_is_r0 ? '0 : b_q;

  // R10
  r0_read_chk: assert property (@(posedge clk) (raddr_a == '0) |=> (rdata_a == '0));
endmodule

// File: rtl/mcdp_pc.sv
module mcdp_pc #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            wr_cond,
  input  logic            zero,
  input  logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] pc
);
  logic load;
  assign load = wr | (wr_cond & zero);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= npc;
  end

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc == '0));
  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && !(wr_cond && zero)) |=> $stable(pc));
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
  import mcdp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pc_wr,
  input  logic             pc_wr_cond,
  input  logic             addr_from_alu,
  input  logic             ir_load,
  input  logic             opa_from_reg,
  input  logic [1:0]       opb_sel,
  input  logic [2:0]       alu_op,
  input  logic [1:0]       npc_sel,
  input  logic             rf_we,
  input  logic             dst_from_rd,
  input  logic             wb_from_mdr,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [5:0]       opcode,
  output logic [5:0]       funct,
  output logic             alu_zero
);
  localparam int RAW  = $clog2(NREGS);
  localparam int IMMW = 16;
  localparam int JIDW = 26;

  logic [XLEN-1:0] pc, ir, mdr, alu_q;
  logic [XLEN-1:0] opnd_a, opnd_b;
  logic [XLEN-1:0] alu_in_a, alu_in_b, alu_y, npc;
  logic [XLEN-1:0] imm_sx, jump_tgt, wb_data;
  logic [RAW-1:0]  dst_reg;

  // Instruction register: loads only on request.
  always_ff @(posedge clk) begin
    if (rst)          ir <= '0;
    else if (ir_load) ir <= mem_rdata;
  end

  // Intermediate registers load every edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      mdr   <= '0;
      alu_q <= '0;
    end else begin
      mdr   <= mem_rdata;
      alu_q <= alu_y;
    end
  end

  assign imm_sx   = {{(XLEN-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};
  assign jump_tgt = {pc[XLEN-1 -: 4], ir[JIDW-1:0], 2'b00};
  assign dst_reg  = dst_from_rd ? ir[11 +: RAW] : ir[16 +: RAW];
  assign wb_data  = wb_from_mdr ? mdr : alu_q;

  mcdp_regfile #(.XLEN(XLEN), .NREGS(NREGS)) rf_i (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (dst_reg),
    .wdata   (wb_data),
    .raddr_a (ir[21 +: RAW]),
    .raddr_b (ir[16 +: RAW]),
    .rdata_a (opnd_a),
    .rdata_b (opnd_b)
  );

  assign alu_in_a = opa_from_reg ? opnd_a : pc;

  always_comb begin
    unique case (opb_sel_e'(opb_sel))
      OPB_REG:    alu_in_b = opnd_b;
      OPB_FOUR:   alu_in_b = XLEN'(4);
      OPB_IMM:    alu_in_b = imm_sx;
      OPB_IMM_X4: alu_in_b = {imm_sx[XLEN-3:0], 2'b00};
      default:    alu_in_b = opnd_b;
    endcase
  end

  mcdp_alu #(.XLEN(XLEN)) alu_i (
    .op   (alu_op_e'(alu_op)),
    .a    (alu_in_a),
    .b    (alu_in_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    unique case (npc_sel_e'(npc_sel))
      NPC_HELD: npc = alu_q;
      NPC_JUMP: npc = jump_tgt;
      default:  npc = alu_y;
    endcase
  end

  mcdp_pc #(.XLEN(XLEN)) pc_i (
    .clk     (clk),
    .rst     (rst),
    .wr      (pc_wr),
    .wr_cond (pc_wr_cond),
    .zero    (alu_zero),
    .npc     (npc),
    .pc      (pc)
  );

  assign mem_addr  = addr_from_alu ? alu_q : pc;
  assign mem_wdata = opnd_b;
  assign opcode    = ir[31:26];
  assign funct     = ir[5:0];

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ir_load |=> $stable(ir));
  // R6
  alu_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 3'd1) |-> (alu_zero == (alu_in_a == alu_in_b)));
  // R8
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> (pc == $past(npc)));
  // R4
  mdr_load_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mdr == $past(mem_rdata)));
endmodule

// File: tb/mcdp_top_tb_top.sv
`timescale 1ns/1ps
module mcdp_top_tb_top;
  localparam int K_ADDR = 0;
  localparam int K_WD   = 1;
  localparam int K_OPC  = 2;
  localparam int K_FUN  = 3;
  localparam int K_ZERO = 4;

  typedef struct {
    int          kind;
    logic [31:0] expv;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst;
  logic pc_wr, pc_wr_cond, addr_from_alu, ir_load, opa_from_reg;
  logic rf_we, dst_from_rd, wb_from_mdr;
  logic [1:0] opb_sel, npc_sel;
  logic [2:0] alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode, funct;
  logic        alu_zero;

  logic [31:0] mem [256];
  logic [31:0] erf [32];
  logic [31:0] exp_pc, cur, tgt, got;
  item_t       sbq [$];
  item_t       it;
  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  mcdp_top dut_i (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .addr_from_alu(addr_from_alu), .ir_load(ir_load), .opa_from_reg(opa_from_reg),
    .opb_sel(opb_sel), .alu_op(alu_op), .npc_sel(npc_sel), .rf_we(rf_we),
    .dst_from_rd(dst_from_rd), .wb_from_mdr(wb_from_mdr), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct),
    .alu_zero(alu_zero)
  );

  // Monitor: pops every expectation queued for this cycle.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        K_ADDR:  got = mem_addr;
        K_WD:    got = mem_wdata;
        K_OPC:   got = {26'd0, opcode};
        K_FUN:   got = {26'd0, funct};
        default: got = {31'd0, alu_zero};
      endcase
      tests++;
      if (got !== it.expv) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.expv);
      end
    end
  end

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] alu_model(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return {31'd0, $signed(a) < $signed(b)};
      5: return a ^ b;
      6: return ~(a | b);
      default: return {31'd0, a < b};
    endcase
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] opc, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {opc, rs, rt, imm};
  endfunction

  task automatic push(input int k, input logic [31:0] v, input string t);
    item_t n;
    n.kind = k; n.expv = v; n.tag = t;
    sbq.push_back(n);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; addr_from_alu = 0; ir_load = 0; opa_from_reg = 0;
    rf_we = 0; dst_from_rd = 0; wb_from_mdr = 0; opb_sel = 0; npc_sel = 0; alu_op = 0;
  endtask

  task automatic fetch(input logic [31:0] ins, input string t);
    mem[exp_pc[9:2]] = ins;
    idle();
    ir_load = 1; opb_sel = 2'd1; pc_wr = 1;
    push(K_ADDR, exp_pc, t);
    tick();
    exp_pc = exp_pc + 4;
    cur = ins;
  endtask

  task automatic decode();
    idle();
    opb_sel = 2'd3;
    push(K_OPC, {26'd0, cur[31:26]}, "R3");
    push(K_FUN, {26'd0, cur[5:0]}, "R3");
    tick();
    tgt = exp_pc + (sx(cur[15:0]) << 2);
  endtask

  task automatic addr_calc();
    idle();
    opa_from_reg = 1; opb_sel = 2'd2;
    tick();
  endtask

  task automatic do_load(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                         input logic [31:0] data);
    logic [31:0] a;
    a = erf[rs] + sx(imm);
    mem[a[9:2]] = data;
    fetch(enc_i(6'h23, rs, rt, imm), "R7");
    decode();
    addr_calc();
    idle(); addr_from_alu = 1;
    push(K_ADDR, a, "R2");
    tick();
    idle(); rf_we = 1; wb_from_mdr = 1;
    tick();
    if (rt != 0) erf[rt] = data;
  endtask

  task automatic do_store(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                          input string t);
    logic [31:0] a;
    a = erf[rs] + sx(imm);
    fetch(enc_i(6'h2b, rs, rt, imm), "R7");
    decode();
    addr_calc();
    idle(); addr_from_alu = 1;
    push(K_ADDR, a, t);
    push(K_WD, erf[rt], "R4");
    tick();
    mem[a[9:2]] = erf[rt];
  endtask

  task automatic do_rtype(input int op, input logic [4:0] rd, input logic [4:0] rs,
                          input logic [4:0] rt);
    logic [31:0] res;
    res = alu_model(op, erf[rs], erf[rt]);
    fetch({6'd0, rs, rt, rd, 5'd0, 6'h20 + 6'(op)}, "R7");
    decode();
    idle(); opa_from_reg = 1; alu_op = 3'(op);
    push(K_ZERO, {31'd0, res == 0}, "R6");
    tick();
    idle(); rf_we = 1; dst_from_rd = 1;
    tick();
    if (rd != 0) erf[rd] = res;
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
    fetch(enc_i(6'h04, rs, rt, off), "R7");
    decode();
    idle(); opa_from_reg = 1; alu_op = 3'd1; pc_wr_cond = 1; npc_sel = 2'd1;
    push(K_ZERO, {31'd0, erf[rs] == erf[rt]}, "R6");
    tick();
    if (erf[rs] == erf[rt]) exp_pc = tgt;
  endtask

  task automatic do_jump(input logic [25:0] idx);
    fetch({6'h02, idx}, "R7");
    idle(); npc_sel = 2'd2; pc_wr = 1;
    tick();
    exp_pc = {exp_pc[31:28], idx, 2'b00};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) erf[i] = 32'd0;
    idle();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    exp_pc = 0;

    // R1: first fetch after reset is from address 0
    fetch(enc_i(6'h23, 5'd0, 5'd1, 16'h0200), "R1");
    decode(); addr_calc();
    mem[32'h200 >> 2] = 32'h1234_5678;
    idle(); addr_from_alu = 1; push(K_ADDR, 32'h200, "R2"); tick();
    idle(); rf_we = 1; wb_from_mdr = 1; tick();
    erf[1] = 32'h1234_5678;

    do_load(5'd2, 5'd0, 16'h0204, 32'hFFFF_FFF0);
    do_load(5'd4, 5'd0, 16'h0208, 32'h0000_0220);
    do_load(5'd7, 5'd0, 16'h020C, 32'h0000_0005);

    // R9: rt destination and memory data write-back seen via store data
    do_store(5'd1, 5'd0, 16'h0210, "R9");
    // R5: negative offset through the sign-extended immediate
    do_store(5'd2, 5'd4, 16'hFFF8, "R5");

    // R6: every ALU operation, result brought out by a store
    for (int op = 0; op < 8; op++) begin
      do_rtype(op, 5'd5, 5'd1, 5'd2);
      do_store(5'd5, 5'd0, 16'h0214, "R6");
    end
    do_rtype(4, 5'd6, 5'd2, 5'd7);
    do_store(5'd6, 5'd0, 16'h0214, "R6");
    do_rtype(7, 5'd6, 5'd2, 5'd7);
    do_store(5'd6, 5'd0, 16'h0214, "R6");
    do_rtype(1, 5'd6, 5'd1, 5'd1);

    // R10: write to register 0 ignored, reads back zero
    do_rtype(0, 5'd0, 5'd1, 5'd2);
    do_store(5'd0, 5'd0, 16'h0218, "R10");

    // R3: IR holds while memory presents a different word
    fetch(enc_i(6'h2b, 5'd0, 5'd1, 16'h0011), "R7");
    mem[exp_pc[9:2]] = 32'hFC00_003F;
    idle();
    push(K_OPC, 32'h2b, "R3");
    push(K_FUN, 32'h11, "R3");
    push(K_ADDR, exp_pc, "R3");
    tick();

    // R7/R8: taken branch to the held target, then not-taken
    do_beq(5'd1, 5'd1, 16'd3);
    do_beq(5'd1, 5'd2, 16'd3);
    do_store(5'd1, 5'd0, 16'h021C, "R8");

    // R8: jump target
    do_jump(26'h40);
    fetch(enc_i(6'h2b, 5'd0, 5'd4, 16'h0220), "R8");
    decode(); addr_calc();

    // R1: reset mid-run returns PC to zero
    idle(); rst = 1; tick(); rst = 0;
    exp_pc = 0;
    fetch(32'd0, "R1");

    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule